// File: doc/BRIEF.md
# Coherence Request Issue Arbiter

This block is the front-end issue stage of a directory cache controller. In every cycle it looks at three pending sources: the head of the local replacement queue, a coherence response arriving from the network, and a coherence request arriving from the network. It decides which one, if any, enters the controller pipeline. A source can be chosen only when it is eligible. Eligibility depends on the source kind, on a lookup in the pending-transaction table, on a small protocol stall table, on whether the downstream stages are busy, and on whether the outgoing networks can take traffic.

The transaction table, the caches and the networks are outside the block. The block drives a tag and set index for each source's own table lookup port, and it receives the hit flag and entry index back for every port. For the request port it also receives the valid bit, directory state and owner of the entry that was hit. The chosen source gets an accept or dequeue pulse combinationally in the same cycle. The chosen message is registered and presented to the next stage one clock later, together with its table hit flag and table index.

Top module: `coh_issue_arbiter`

## Requirements
- R1: The replacement source (code 0) is eligible only when all of the following hold: `rq_nonempty` is high, `tbl_full` is low, lookup port 0 misses, `dn2_pending` and `dn3_pending` are both low, and both `net_fwd_avail` and `net_rsp_avail` are high.
- R2: The request source (code 2) is eligible when `req_valid` is high and it meets the same full, pending and network conditions as R1. On top of that, one of three table conditions must hold: lookup port 2 misses; or it hits an entry whose valid bit is low; or it hits a valid entry and the stall table does not stall.
- R3: The response source (code 1) is eligible whenever `rsp_valid` is high. It is never blocked by table, pending or network conditions.
- R4: When more than one source is eligible, replacement wins over response, and response wins over request.
- R5: The stall table stalls exactly when three things are true. First, the hit entry's state is transient, which means state bit 2 is set: the codes are N=0, I=1, S=2, M=3, S_D=4, MN_A=5, SN_A=6, NS_D=7. Second, the sender equals the recorded owner. Third, the message type is GetS (0), GetM (1) or replacement (4). The other type codes are PutS=2, PutM=3, data=5 and ack=6.
- R6: For each lookup port p (0 replacement, 1 response, 2 request), `lk_tag[p]` is address bits [ADDR_W-1:OFF_W+SET_W] of that source and `lk_set[p]` is bits [OFF_W+SET_W-1:OFF_W].
- R7: At most one of `rq_deq`, `rsp_accept` and `req_accept` is high in a cycle, and it is high in the same cycle as the eligibility that caused it.
- R8: The cycle after a source is accepted, `iss_valid` is high. In that cycle `iss_sel` carries the source code, `iss_addr`, `iss_type` and `iss_src` carry the message fields, and `iss_hit` and `iss_idx` carry that source's lookup result. A replacement issues with type 4 and source 0.
- R9: In a cycle where no source is eligible, no accept is raised, and `iss_valid` is low in the next cycle.
- R10: While `rst_n` is low, `iss_valid` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rq_nonempty | input | 1 | Replacement queue holds an entry |
| rq_addr | input | ADDR_W | Address at replacement queue head |
| rq_deq | output | 1 | Dequeue pulse to replacement queue |
| rsp_valid | input | 1 | Network presents a response |
| rsp_addr | input | ADDR_W | Response address |
| rsp_type | input | 3 | Response message type |
| rsp_src | input | NODE_W | Response sender |
| rsp_accept | output | 1 | Response taken |
| req_valid | input | 1 | Network presents a request |
| req_addr | input | ADDR_W | Request address |
| req_type | input | 3 | Request message type |
| req_src | input | NODE_W | Request sender |
| req_accept | output | 1 | Request taken |
| lk_tag | output | 3 x TAG_W | Lookup tag per port |
| lk_set | output | 3 x SET_W | Lookup set index per port |
| tbl_full | input | 1 | Transaction table has no free entry |
| lk_hit | input | 3 | Lookup hit per port |
| lk_idx | input | 3 x TIDX_W | Hit entry index per port |
| lk_ent_valid | input | 1 | Valid bit of request-port hit entry |
| lk_state | input | 3 | Directory state of request-port hit entry |
| lk_owner | input | NODE_W | Owner of request-port hit entry |
| dn2_pending | input | 1 | Second stage busy |
| dn3_pending | input | 1 | Third stage busy |
| net_fwd_avail | input | 1 | Forwarded-request network can accept |
| net_rsp_avail | input | 1 | Response network can accept |
| iss_valid | output | 1 | Issued message valid |
| iss_sel | output | 2 | Issued source code |
| iss_addr | output | ADDR_W | Issued address |
| iss_type | output | 3 | Issued message type |
| iss_src | output | NODE_W | Issued sender |
| iss_hit | output | 1 | Issued source's table hit |
| iss_idx | output | TIDX_W | Issued source's table index |

## Verification
The hardest case to reach is a request that hits a valid table entry. Whether that request issues depends on three things at once: the entry's transient state, the message type, and whether the sender matches the recorded owner. It issues only when nothing with higher priority is eligible. The stimulus keeps the replacement and response sources quiet and holds a table hit on the request port. It then steps through transient and stable states, stalling and non-stalling message types, and owner-matching and non-matching senders. It also sets up a blocked replacement next to an eligible request, to show that a higher-priority source loses the cycle when it is not eligible.

// File: rtl/coh_arb_pkg.sv
// Package: shared encodings for the coherence issue arbiter.
// Assumes 3-bit state and message-type codes; bit 2 of a state marks a transient state.
package coh_arb_pkg;
    typedef enum logic [2:0] {
        ST_N = 3'd0, ST_I = 3'd1, ST_S = 3'd2, ST_M = 3'd3,
        ST_S_D = 3'd4, ST_MN_A = 3'd5, ST_SN_A = 3'd6, ST_NS_D = 3'd7
    } dir_state_e;

    typedef enum logic [2:0] {
        MT_GETS = 3'd0, MT_GETM = 3'd1, MT_PUTS = 3'd2, MT_PUTM = 3'd3,
        MT_REPL = 3'd4, MT_DATA = 3'd5, MT_ACK = 3'd6
    } msg_type_e;

    localparam int NUM_SRC = 3;
    localparam int SEL_W   = 2;
    localparam int SRC_RPL = 0;
    localparam int SRC_RSP = 1;
    localparam int SRC_REQ = 2;
endpackage

// File: rtl/coh_stall_table.sv
// Stall table: combinational lookup deciding whether a request on a block must wait.
// Assumes the caller only uses the result when the block hit a valid table entry.
module coh_stall_table
    import coh_arb_pkg::*;
(
    input  logic [2:0] blk_state,
    input  logic [2:0] msg_type,
    input  logic       from_owner,
    output logic       stall
);
    logic transient;
    logic blocking_type;

    // Classify the state and message type, then combine.
    always_comb begin
        transient     = blk_state[2];
        blocking_type = (msg_type == MT_GETS) || (msg_type == MT_GETM) ||
                        (msg_type == MT_REPL);
        stall         = transient && from_owner && blocking_type;
    end
endmodule

// File: rtl/coh_addr_split.sv
// Address splitter: extracts the tag and set index that a table lookup port expects.
// Assumes a line offset of OFF_W low bits that the lookup ignores.
module coh_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int SET_W  = 6,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [SET_W-1:0]  set_idx
);
    // Slice the address into its lookup fields.
    always_comb begin
        tag     = addr[ADDR_W-1:OFF_W+SET_W];
        set_idx = addr[OFF_W+SET_W-1:OFF_W];
    end
endmodule

// File: rtl/coh_fixed_prio.sv
// Fixed-priority picker: grants the lowest-indexed asserted request.
// Assumes requests are already qualified; the grant is one-hot or zero.
module coh_fixed_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant
);
    logic taken;

    // Walk from index 0 upward and grant the first eligible entry.
    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_issue_arbiter.sv
// Issue arbiter: picks one of replacement / response / request per cycle,
// pulses the winner's handshake combinationally and registers the issued message.
// Assumes source inputs stay stable until accepted and lookup results are combinational.
module coh_issue_arbiter
    import coh_arb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int SET_W  = 6,
    parameter int NODE_W = 4,
    parameter int TIDX_W = 3,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rq_nonempty,
    input  logic [ADDR_W-1:0]                 rq_addr,
    output logic                              rq_deq,
    input  logic                              rsp_valid,
    input  logic [ADDR_W-1:0]                 rsp_addr,
    input  logic [2:0]                        rsp_type,
    input  logic [NODE_W-1:0]                 rsp_src,
    output logic                              rsp_accept,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [2:0]                        req_type,
    input  logic [NODE_W-1:0]                 req_src,
    output logic                              req_accept,
    output logic [NUM_SRC-1:0][TAG_W-1:0]     lk_tag,
    output logic [NUM_SRC-1:0][SET_W-1:0]     lk_set,
    input  logic                              tbl_full,
    input  logic [NUM_SRC-1:0]                lk_hit,
    input  logic [NUM_SRC-1:0][TIDX_W-1:0]    lk_idx,
    input  logic                              lk_ent_valid,
    input  logic [2:0]                        lk_state,
    input  logic [NODE_W-1:0]                 lk_owner,
    input  logic                              dn2_pending,
    input  logic                              dn3_pending,
    input  logic                              net_fwd_avail,
    input  logic                              net_rsp_avail,
    output logic                              iss_valid,
    output logic [SEL_W-1:0]                  iss_sel,
    output logic [ADDR_W-1:0]                 iss_addr,
    output logic [2:0]                        iss_type,
    output logic [NODE_W-1:0]                 iss_src,
    output logic                              iss_hit,
    output logic [TIDX_W-1:0]                 iss_idx
);
    logic [NUM_SRC-1:0][ADDR_W-1:0] src_addr;
    logic [NUM_SRC-1:0]             elig;
    logic [NUM_SRC-1:0]             grant;
    logic                           path_free;
    logic                           req_tbl_ok;
    logic                           req_stall;
    logic                           req_from_owner;
    logic [SEL_W-1:0]               nx_sel;
    logic [ADDR_W-1:0]              nx_addr;
    logic [2:0]                     nx_type;
    logic [NODE_W-1:0]              nx_src;

    assign src_addr[SRC_RPL] = rq_addr;
    assign src_addr[SRC_RSP] = rsp_addr;
    assign src_addr[SRC_REQ] = req_addr;

    // One address splitter per lookup port.
    for (genvar p = 0; p < NUM_SRC; p++) begin : g_lookup
        coh_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) i_split (
            .addr    (src_addr[p]),
            .tag     (lk_tag[p]),
            .set_idx (lk_set[p])
        );
    end

    assign req_from_owner = (req_src == lk_owner);

    coh_stall_table i_stall (
        .blk_state  (lk_state),
        .msg_type   (req_type),
        .from_owner (req_from_owner),
        .stall      (req_stall)
    );

    // Qualify each source against table, pipeline and network conditions.
    always_comb begin
        path_free     = !dn2_pending && !dn3_pending && net_fwd_avail && net_rsp_avail;
        req_tbl_ok    = !lk_hit[SRC_REQ] || !lk_ent_valid || !req_stall;
        elig[SRC_RPL] = rq_nonempty && !tbl_full && !lk_hit[SRC_RPL] && path_free;
        elig[SRC_RSP] = rsp_valid;
        elig[SRC_REQ] = req_valid && !tbl_full && req_tbl_ok && path_free;
    end

    coh_fixed_prio #(.N(NUM_SRC)) i_prio (
        .elig  (elig),
        .grant (grant)
    );

    assign rq_deq     = grant[SRC_RPL];
    assign rsp_accept = grant[SRC_RSP];
    assign req_accept = grant[SRC_REQ];

    // Steer the granted source's fields toward the output register.
    always_comb begin
        nx_sel  = SEL_W'(SRC_REQ);
        nx_addr = req_addr;
        nx_type = req_type;
        nx_src  = req_src;
        if (grant[SRC_RPL]) begin
            nx_sel  = SEL_W'(SRC_RPL);
            nx_addr = rq_addr;
            nx_type = MT_REPL;
            nx_src  = '0;
        end else if (grant[SRC_RSP]) begin
            nx_sel  = SEL_W'(SRC_RSP);
            nx_addr = rsp_addr;
            nx_type = rsp_type;
            nx_src  = rsp_src;
        end
    end

    // Register the issued message for the next pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_sel   <= '0;
            iss_addr  <= '0;
            iss_type  <= '0;
            iss_src   <= '0;
            iss_hit   <= 1'b0;
            iss_idx   <= '0;
        end else begin
            iss_valid <= |grant;
            if (|grant) begin
                iss_sel  <= nx_sel;
                iss_addr <= nx_addr;
                iss_type <= nx_type;
                iss_src  <= nx_src;
                iss_hit  <= lk_hit[nx_sel];
                iss_idx  <= lk_idx[nx_sel];
            end
        end
    end
endmodule

// File: rtl/coh_issue_arbiter_chk.sv
// Checker: temporal properties of the issue arbiter, observed at its ports.
// Assumes it is attached through the bind below.
module coh_issue_arbiter_chk #(
    parameter int ADDR_W = 32,
    parameter int NODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rq_nonempty,
    input logic              rq_deq,
    input logic              rsp_valid,
    input logic              rsp_accept,
    input logic              req_valid,
    input logic [2:0]        req_type,
    input logic [NODE_W-1:0] req_src,
    input logic              req_accept,
    input logic              tbl_full,
    input logic [2:0]        lk_hit,
    input logic              lk_ent_valid,
    input logic [2:0]        lk_state,
    input logic [NODE_W-1:0] lk_owner,
    input logic              dn2_pending,
    input logic              dn3_pending,
    input logic              net_fwd_avail,
    input logic              net_rsp_avail,
    input logic              iss_valid,
    input logic [1:0]        iss_sel,
    input logic [2:0]        iss_type
);
    p_rpl_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rq_deq |-> (rq_nonempty && !tbl_full && !lk_hit[0] && !dn2_pending &&
                    !dn3_pending && net_fwd_avail && net_rsp_avail));

    p_req_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> (req_valid && !tbl_full && !dn2_pending && !dn3_pending &&
                        net_fwd_avail && net_rsp_avail));

    p_rsp_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rq_deq) |-> rsp_accept);

    p_req_after_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> !rsp_valid);

    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit[2] && lk_ent_valid && lk_state[2] && (req_src == lk_owner) &&
         (req_type == 3'd0 || req_type == 3'd1 || req_type == 3'd4)) |-> !req_accept);

    p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rq_deq, rsp_accept, req_accept}));

    p_issue_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_deq || rsp_accept || req_accept) |=> iss_valid);

    p_rpl_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rq_deq |=> (iss_sel == 2'd0 && iss_type == 3'd4));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_deq || rsp_accept || req_accept) |=> !iss_valid);

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !iss_valid);
endmodule

bind coh_issue_arbiter coh_issue_arbiter_chk #(.ADDR_W(ADDR_W), .NODE_W(NODE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .rq_nonempty(rq_nonempty), .rq_deq(rq_deq),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .req_valid(req_valid),
    .req_type(req_type), .req_src(req_src), .req_accept(req_accept),
    .tbl_full(tbl_full), .lk_hit(lk_hit), .lk_ent_valid(lk_ent_valid),
    .lk_state(lk_state), .lk_owner(lk_owner), .dn2_pending(dn2_pending),
    .dn3_pending(dn3_pending), .net_fwd_avail(net_fwd_avail),
    .net_rsp_avail(net_rsp_avail), .iss_valid(iss_valid), .iss_sel(iss_sel),
    .iss_type(iss_type)
);

// File: tb/test_coh_issue_arbiter.sv
module test_coh_issue_arbiter;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 6;
    localparam int SET_W  = 6;
    localparam int NODE_W = 4;
    localparam int TIDX_W = 3;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    logic clk = 0;
    logic rst_n = 0;
    logic rq_nonempty, rsp_valid, req_valid;
    logic [ADDR_W-1:0] rq_addr, rsp_addr, req_addr;
    logic [2:0] rsp_type, req_type;
    logic [NODE_W-1:0] rsp_src, req_src;
    logic rq_deq, rsp_accept, req_accept;
    logic [2:0][TAG_W-1:0] lk_tag;
    logic [2:0][SET_W-1:0] lk_set;
    logic tbl_full;
    logic [2:0] lk_hit;
    logic [2:0][TIDX_W-1:0] lk_idx;
    logic lk_ent_valid;
    logic [2:0] lk_state;
    logic [NODE_W-1:0] lk_owner;
    logic dn2_pending, dn3_pending, net_fwd_avail, net_rsp_avail;
    logic iss_valid, iss_hit;
    logic [1:0] iss_sel;
    logic [ADDR_W-1:0] iss_addr;
    logic [2:0] iss_type;
    logic [NODE_W-1:0] iss_src;
    logic [TIDX_W-1:0] iss_idx;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic              v;
        logic [1:0]        sel;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        typ;
        logic [NODE_W-1:0] src;
        logic              hit;
        logic [TIDX_W-1:0] idx;
        string             tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    coh_issue_arbiter i_coh_issue_arbiter (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        rq_nonempty = 0; rsp_valid = 0; req_valid = 0;
        rq_addr = 32'h1000_0040; rsp_addr = 32'h2000_0080; req_addr = 32'h3000_00C0;
        rsp_type = 3'd5; req_type = 3'd0; rsp_src = 4'd3; req_src = 4'd5;
        tbl_full = 0; lk_hit = 3'b000; lk_idx = {3'd6, 3'd5, 3'd4};
        lk_ent_valid = 0; lk_state = 3'd0; lk_owner = 4'd9;
        dn2_pending = 0; dn3_pending = 0; net_fwd_avail = 1; net_rsp_avail = 1;
    endtask

    function automatic logic stall_m();
        return lk_state[2] && (req_src == lk_owner) &&
               (req_type == 3'd0 || req_type == 3'd1 || req_type == 3'd4);
    endfunction

    // Driver: evaluate one cycle's stimulus, check handshakes, push expected issue.
    task automatic step(string req);
        logic free, e_rpl, e_rsp, e_req;
        exp_t e;
        #1;
        free  = !dn2_pending && !dn3_pending && net_fwd_avail && net_rsp_avail;
        e_rpl = rq_nonempty && !tbl_full && !lk_hit[0] && free;
        e_rsp = rsp_valid;
        e_req = req_valid && !tbl_full && free &&
                (!lk_hit[2] || !lk_ent_valid || !stall_m());
        e = '{v: 0, sel: 0, addr: 0, typ: 0, src: 0, hit: 0, idx: 0, tag: req};
        if (e_rpl) begin
            e = '{v: 1, sel: 0, addr: rq_addr, typ: 3'd4, src: 0, hit: lk_hit[0], idx: lk_idx[0], tag: req};
        end else if (e_rsp) begin
            e = '{v: 1, sel: 1, addr: rsp_addr, typ: rsp_type, src: rsp_src, hit: lk_hit[1], idx: lk_idx[1], tag: req};
        end else if (e_req) begin
            e = '{v: 1, sel: 2, addr: req_addr, typ: req_type, src: req_src, hit: lk_hit[2], idx: lk_idx[2], tag: req};
        end
        check({req, " R7 accepts"}, {61'd0, req_accept, rsp_accept, rq_deq},
              {61'd0, e.v && e.sel == 2, e.v && e.sel == 1, e.v && e.sel == 0});
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: after every active edge, pop one expected item and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R8/R9 iss_valid"}, 64'(iss_valid), 64'(e.v));
                if (e.v) begin
                    check({e.tag, " R8 iss_sel"},  64'(iss_sel),  64'(e.sel));
                    check({e.tag, " R8 iss_addr"}, 64'(iss_addr), 64'(e.addr));
                    check({e.tag, " R8 iss_type"}, 64'(iss_type), 64'(e.typ));
                    check({e.tag, " R8 iss_src"},  64'(iss_src),  64'(e.src));
                    check({e.tag, " R8 iss_hit"},  64'(iss_hit),  64'(e.hit));
                    check({e.tag, " R8 iss_idx"},  64'(iss_idx),  64'(e.idx));
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R10 reset iss_valid", 64'(iss_valid), 0);
        rst_n = 1;
        @(negedge clk);

        // R9: nothing pending
        step("R9 idle");

        // R6: lookup address split per port
        rq_addr = 32'hABCD_E7C0; rsp_addr = 32'h1234_5FC0; req_addr = 32'hFEDC_B040;
        #1;
        check("R6 tag rpl", 64'(lk_tag[0]), 64'(rq_addr[31:12]));
        check("R6 set rpl", 64'(lk_set[0]), 64'(rq_addr[11:6]));
        check("R6 tag rsp", 64'(lk_tag[1]), 64'(rsp_addr[31:12]));
        check("R6 set rsp", 64'(lk_set[1]), 64'(rsp_addr[11:6]));
        check("R6 tag req", 64'(lk_tag[2]), 64'(req_addr[31:12]));
        check("R6 set req", 64'(lk_set[2]), 64'(req_addr[11:6]));

        // R3: response ignores full, pending and network
        rsp_valid = 1; tbl_full = 1; dn2_pending = 1; net_fwd_avail = 0; lk_hit = 3'b010;
        step("R3 response unblocked");
        idle();

        // R1: replacement clean, then each blocker
        rq_nonempty = 1; step("R1 rpl clean");
        tbl_full = 1;    step("R1 rpl full");     tbl_full = 0;
        lk_hit[0] = 1;   step("R1 rpl hit");      lk_hit[0] = 0;
        dn3_pending = 1; step("R1 rpl dn3");      dn3_pending = 0;
        net_fwd_avail = 0; step("R1 rpl fwd net"); net_fwd_avail = 1;
        net_rsp_avail = 0; step("R1 rpl rsp net"); net_rsp_avail = 1;

        // R4: priority
        rsp_valid = 1; req_valid = 1; step("R4 all eligible");
        rq_nonempty = 0;              step("R4 rsp over req");
        rq_nonempty = 1; lk_hit[0] = 1; rsp_valid = 0; step("R4 blocked rpl yields req");
        idle();

        // R2: request table cases
        req_valid = 1; step("R2 req miss");
        lk_hit[2] = 1; lk_ent_valid = 0; lk_state = 3'd4; req_src = lk_owner;
        step("R2 req hit invalid entry");
        dn2_pending = 1; lk_hit[2] = 0; step("R2 req dn2 blocked"); dn2_pending = 0;
        tbl_full = 1; step("R2 req full"); tbl_full = 0;

        // R5: stall table through the request path
        lk_hit[2] = 1; lk_ent_valid = 1; lk_state = 3'd4; req_src = lk_owner;
        req_type = 3'd0; step("R5 S_D owner GetS stalls");
        req_type = 3'd1; step("R5 S_D owner GetM stalls");
        lk_state = 3'd5; req_type = 3'd4; step("R5 MN_A owner repl stalls");
        lk_state = 3'd7; req_type = 3'd3; step("R5 NS_D owner PutM issues");
        lk_state = 3'd4; req_type = 3'd0; req_src = 4'd2; step("R5 non-owner issues");
        lk_state = 3'd3; req_src = lk_owner; step("R5 stable M issues");
        idle();
        step("R9 idle end");

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 64'(sb.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule